// File: doc/BRIEF.md
# Early-Exit Iterative Multiply-Accumulate Unit

This block multiplies two 32-bit operands over several clock cycles and can add an accumulator value to the product. One control input selects a plain product or a product plus accumulator. A second selects a 32-bit result or a 64-bit result. A third selects whether both operands are two's complement or unsigned. A single-cycle start strobe launches an operation. The block then raises its busy flag and, when the result is ready, pulses a done strobe for one cycle. The result stays on the output until the next operation completes.

The multiplier operand B is consumed one byte per cycle, lowest byte first. Before the first step the block measures how many bytes B really occupies: it drops the upper bytes that only repeat zeros, or in signed mode that only repeat the sign. Only the bytes that remain are processed, so small multipliers finish sooner. In signed mode the topmost byte that is processed is weighted as a signed byte. No guard bits are kept: every sum wraps at the selected result width. In 64-bit accumulate mode the 64-bit addend is added in two extra cycles, one 32-bit half per cycle, with the carry held in a register between them.

Top module: `emac_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no start, busy_o and done_o are 0 and result_o is 0.
- R2: A start_i pulse sampled while busy_o is 0 is accepted: busy_o is 1 in the following cycle.
- R3: If start is accepted at clock edge E0, done_o rises after edge E(L-1), where L = 1 + k + 2·(acc_mode_i & wide_i) and k is the step count (1 to 4) of R4/R5. Between operations the start-to-start period is also L, so L ranges from 2 to 7.
- R4: With signed_i = 0, k is the smallest s in {1,2,3} for which B < 2^(8s), and otherwise 4.
- R5: With signed_i = 1, k is the smallest s in {1,2,3} for which -2^(8s-1) ≤ B < 2^(8s-1), with B read as two's complement, and otherwise 4.
- R6: With wide_i = 0, result_o[31:0] = (A·B + (acc_mode_i ? acc_i[31:0] : 0)) mod 2^32 and result_o[63:32] = 0.
- R7: With wide_i = 1, result_o = (A·B + (acc_mode_i ? acc_i : 0)) mod 2^64. A and B are sign-extended when signed_i = 1 and zero-extended when signed_i = 0.
- R8: done_o is high for exactly one cycle, with busy_o low in that cycle. result_o keeps its value until the next operation completes.
- R9: A start_i pulse while busy_o is 1 is ignored. The running operation's result and latency are unchanged, and operand inputs that change during the operation have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, sampled while idle |
| a_i | input | 32 | Multiplicand A |
| b_i | input | 32 | Multiplier B; its significant length sets the step count |
| acc_i | input | 64 | Accumulator addend; only bits [31:0] are used in 32-bit precision |
| acc_mode_i | input | 1 | 1 = add accumulator, 0 = plain product |
| wide_i | input | 1 | 1 = 64-bit result, 0 = 32-bit result |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 64 | Result, held between completions |

## Verification
The B operand is swept across values just inside and just outside each byte boundary, in both signednesses. Examples are 0x7F against 0x80, 0xFFFFFF80 against 0xFFFFFF7F, and all ones. These show whether the step count, and the signed weighting of the top processed byte, are chosen correctly. The A operand is swept over zero, one, all ones, the most negative value and a mixed pattern, which separates sign extension from zero extension of the multiplicand. Each pair runs in all eight mode combinations against an all-ones and a mixed accumulator, which shows wrap at the result width and the carry between the two accumulate halves. Random operands and start pulses during busy cover everything else.

// File: rtl/emac_pkg.sv
package emac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STEP   = 2'd1,
    ST_ACC_LO = 2'd2,
    ST_ACC_HI = 2'd3
  } emac_state_e;

  typedef struct packed {
    logic acc;
    logic wide;
    logic sgn;
  } emac_mode_t;

endpackage

// File: rtl/emac_len_detect.sv
module emac_len_detect #(
  parameter  int DATA_W  = 32,
  parameter  int SLICE_W = 8,
  localparam int NSLICE  = DATA_W / SLICE_W,
  localparam int CNT_W   = $clog2(NSLICE + 1)
) (
  input  logic [DATA_W-1:0] b_i,
  input  logic              sgn_i,
  output logic [CNT_W-1:0]  steps_o
);

  // fits[i]: B is fully represented by its lowest i+1 slices
  logic [NSLICE-1:0] fits;

  for (genvar s = 1; s < NSLICE; s++) begin : g_fit
    localparam int LO_U = s * SLICE_W;
    localparam int LO_S = s * SLICE_W - 1;
    logic [DATA_W-LO_S-1:0] upper_s;
    logic                   zero_u;
    assign upper_s   = b_i[DATA_W-1:LO_S];
    assign zero_u    = ~(|b_i[DATA_W-1:LO_U]);
    assign fits[s-1] = sgn_i ? ((&upper_s) | ~(|upper_s)) : zero_u;
  end

  assign fits[NSLICE-1] = 1'b1;

  always_comb begin
    steps_o = CNT_W'(NSLICE);
    for (int i = NSLICE - 1; i >= 0; i--) begin
      if (fits[i]) steps_o = CNT_W'(i + 1);
    end
  end

endmodule

// File: rtl/emac_pp_step.sv
module emac_pp_step #(
  parameter  int DATA_W  = 32,
  parameter  int SLICE_W = 8,
  localparam int NSLICE  = DATA_W / SLICE_W,
  localparam int IDX_W   = (NSLICE > 1) ? $clog2(NSLICE) : 1,
  localparam int PW      = 2 * DATA_W,
  localparam int SH_W    = $clog2(PW)
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic               a_sgn_i,
  input  logic [SLICE_W-1:0] slice_i,
  input  logic               slice_sgn_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [PW-1:0]      pp_o
);

  logic signed [PW-1:0]    a_ext;
  logic signed [SLICE_W:0] s_ext;
  logic signed [PW-1:0]    s_wide;
  logic signed [PW-1:0]    prod;
  logic        [SH_W-1:0]  shamt;

  always_comb begin
    a_ext  = {{DATA_W{a_sgn_i & a_i[DATA_W-1]}}, a_i};
    s_ext  = {slice_sgn_i & slice_i[SLICE_W-1], slice_i};
    s_wide = PW'(s_ext);
    prod   = a_ext * s_wide;
    shamt  = SH_W'(idx_i) * SH_W'(SLICE_W);
    pp_o   = prod << shamt;
  end

endmodule

// File: rtl/emac_add.sv
module emac_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};

endmodule

// File: rtl/emac_ctrl.sv
module emac_ctrl
  import emac_pkg::*;
#(
  parameter  int NSLICE = 4,
  localparam int CNT_W  = $clog2(NSLICE + 1),
  localparam int IDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] steps_i,
  input  logic             acc64_i,
  output logic             load_o,
  output logic             step_o,
  output logic             acc_lo_o,
  output logic             acc_hi_o,
  output logic             finish_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o
);

  emac_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] tgt_q;
  logic             cnt_en;

  assign last_o = (cnt_q + CNT_W'(1)) == tgt_q;
  assign idx_o  = cnt_q[IDX_W-1:0];
  assign busy_o = (state_q != ST_IDLE);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    load_o   = 1'b0;
    step_o   = 1'b0;
    acc_lo_o = 1'b0;
    acc_hi_o = 1'b0;
    finish_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          cnt_d   = '0;
          state_d = ST_STEP;
        end
      end
      ST_STEP: begin
        step_o = 1'b1;
        cnt_d  = cnt_q + CNT_W'(1);
        if (last_o) begin
          state_d  = acc64_i ? ST_ACC_LO : ST_IDLE;
          finish_o = ~acc64_i;
        end
      end
      ST_ACC_LO: begin
        acc_lo_o = 1'b1;
        state_d  = ST_ACC_HI;
      end
      ST_ACC_HI: begin
        acc_hi_o = 1'b1;
        finish_o = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_en = load_o | step_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (load_o) tgt_q <= steps_i;
    end
  end

endmodule

// File: rtl/emac_unit.sv
module emac_unit
  import emac_pkg::*;
#(
  parameter  int DATA_W  = 32,
  parameter  int SLICE_W = 8,
  localparam int NSLICE  = DATA_W / SLICE_W,
  localparam int CNT_W   = $clog2(NSLICE + 1),
  localparam int IDX_W   = (NSLICE > 1) ? $clog2(NSLICE) : 1,
  localparam int PW      = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [PW-1:0]     acc_i,
  input  logic              acc_mode_i,
  input  logic              wide_i,
  input  logic              signed_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PW-1:0]     result_o
);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  // control
  logic             load, step, acc_lo, acc_hi, finish, last_step;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] steps_in;
  emac_mode_t       mode_q;

  emac_len_detect #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_len (
    .b_i     (b_i),
    .sgn_i   (signed_i),
    .steps_o (steps_in)
  );

  emac_ctrl #(.NSLICE(NSLICE)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (start_i),
    .steps_i  (steps_in),
    .acc64_i  (mode_q.acc & mode_q.wide),
    .load_o   (load),
    .step_o   (step),
    .acc_lo_o (acc_lo),
    .acc_hi_o (acc_hi),
    .finish_o (finish),
    .last_o   (last_step),
    .idx_o    (idx),
    .busy_o   (busy_o)
  );

  // datapath state
  logic [DATA_W-1:0] a_q, b_sh_q, b_sh_d;
  logic [PW-1:0]     acc_q;
  logic [PW-1:0]     prod_q, prod_d;
  logic [PW-1:0]     result_q, result_d;
  logic              carry_q, done_q;
  emac_mode_t        mode_d;
  logic              prod_en, b_en;

  // partial product of the current byte of B
  logic [PW-1:0] pp;

  emac_pp_step #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_pp (
    .a_i         (a_q),
    .a_sgn_i     (mode_q.sgn),
    .slice_i     (b_sh_q[SLICE_W-1:0]),
    .slice_sgn_i (mode_q.sgn & last_step),
    .idx_i       (idx),
    .pp_o        (pp)
  );

  // half-width adder for the 64-bit accumulate, one half per cycle
  logic [DATA_W-1:0] add_a, add_b, add_sum;
  logic              add_cin, add_cout;

  always_comb begin
    add_a   = acc_hi ? prod_q[PW-1:DATA_W] : prod_q[DATA_W-1:0];
    add_b   = acc_hi ? acc_q[PW-1:DATA_W]  : acc_q[DATA_W-1:0];
    add_cin = acc_hi & carry_q;
  end

  emac_add #(.W(DATA_W)) u_add (
    .a_i    (add_a),
    .b_i    (add_b),
    .cin_i  (add_cin),
    .sum_o  (add_sum),
    .cout_o (add_cout)
  );

  // next-state logic
  always_comb begin
    mode_d.acc  = acc_mode_i;
    mode_d.wide = wide_i;
    mode_d.sgn  = signed_i;

    b_sh_d = load ? b_i : (b_sh_q >> SLICE_W);
    b_en   = load | step;

    prod_d = prod_q;
    if (load) begin
      // narrow accumulate: the addend is folded in as the start value
      prod_d = (acc_mode_i & ~wide_i) ? {{DATA_W{1'b0}}, acc_i[DATA_W-1:0]} : '0;
    end else if (step) begin
      prod_d = prod_q + pp;
    end else if (acc_lo) begin
      prod_d = {prod_q[PW-1:DATA_W], add_sum};
    end else if (acc_hi) begin
      prod_d = {add_sum, prod_q[DATA_W-1:0]};
    end
    prod_en = load | step | acc_lo | acc_hi;

    result_d = mode_q.wide ? prod_d : {{DATA_W{1'b0}}, prod_d[DATA_W-1:0]};
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      a_q      <= '0;
      b_sh_q   <= '0;
      acc_q    <= '0;
      mode_q   <= '0;
      prod_q   <= '0;
      carry_q  <= 1'b0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      if (load) begin
        a_q    <= a_i;
        acc_q  <= acc_i;
        mode_q <= mode_d;
      end
      if (b_en)    b_sh_q   <= b_sh_d;
      if (prod_en) prod_q   <= prod_d;
      if (acc_lo)  carry_q  <= add_cout;
      if (finish)  result_q <= result_d;
      done_q <= finish;
    end
  end

  assign done_o   = done_q;
  assign result_o = result_q;

endmodule

module emac_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] result_hi,
  input logic [DATA_W-1:0] a_q,
  input logic              wide_q
);

  localparam int MAX_BUSY = DATA_W / SLICE_W + 2;

  logic [7:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 8'd1;
    else             busy_cnt <= '0;
  end

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  assert_latency_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (int'(busy_cnt) < MAX_BUSY));

  assert_narrow_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !wide_q) |-> (result_hi == '0));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_operand_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(a_q));

endmodule

bind emac_unit emac_unit_chk #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .result_hi (result_o[PW-1:DATA_W]),
  .a_q       (a_q),
  .wide_q    (mode_q.wide)
);

// File: tb/tb_emac_unit.sv
module tb_emac_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] a_i, b_i;
  logic [63:0] acc_i;
  logic        acc_mode_i, wide_i, signed_i;
  logic        busy_o, done_o;
  logic [63:0] result_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  emac_unit dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .acc_i      (acc_i),
    .acc_mode_i (acc_mode_i),
    .wide_i     (wide_i),
    .signed_i   (signed_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R4 / R5 step count from value ranges
  function automatic int exp_steps(input logic [31:0] b, input bit sg);
    longint v;
    v = sg ? longint'($signed(b)) : longint'(b);
    for (int s = 1; s < 4; s++) begin
      longint lim;
      lim = longint'(1) << (8 * s - (sg ? 1 : 0));
      if (sg ? (v >= -lim && v < lim) : (v < lim)) return s;
    end
    return 4;
  endfunction

  function automatic logic [63:0] exp_result(input logic [31:0] a, input logic [31:0] b,
                                             input logic [63:0] acc, input bit am,
                                             input bit wd, input bit sg);
    logic [63:0] a64, b64, p;
    logic [31:0] lo;
    a64 = sg ? {{32{a[31]}}, a} : {32'h0, a};
    b64 = sg ? {{32{b[31]}}, b} : {32'h0, b};
    p   = a64 * b64;
    if (wd) return p + (am ? acc : 64'h0);
    lo = p[31:0] + (am ? acc[31:0] : 32'h0);
    return {32'h0, lo};
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc,
                        input bit am, input bit wd, input bit sg, input bit poke);
    int          cyc;
    int          exp_l;
    logic [63:0] exp_r;
    logic [63:0] held;
    exp_l = 1 + exp_steps(b, sg) + ((am && wd) ? 2 : 0);
    exp_r = exp_result(a, b, acc, am, wd, sg);
    @(negedge clk);
    a_i = a; b_i = b; acc_i = acc;
    acc_mode_i = am; wide_i = wd; signed_i = sg;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    check(busy_o === 1'b1, "R2", "busy after accepted start", 64'(busy_o), 64'd1);
    if (poke) begin
      // R9: new start and different operands while busy
      start_i = 1'b1;
      a_i = ~a; b_i = b ^ 32'h00FF_0F0F; acc_i = ~acc;
      acc_mode_i = ~am; wide_i = ~wd; signed_i = ~sg;
    end
    while (!done_o && cyc < 20) begin
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    check(cyc == exp_l, sg ? "R3/R5" : "R3/R4", "latency", 64'(cyc), 64'(exp_l));
    check(result_o === exp_r, wd ? "R7" : "R6", "result", result_o, exp_r);
    check(busy_o === 1'b0, "R8", "busy low with done", 64'(busy_o), 64'd0);
    if (poke) check(result_o === exp_r, "R9", "result after ignored start", result_o, exp_r);
    held = result_o;
    @(negedge clk);
    check(done_o === 1'b0, "R8", "done single cycle", 64'(done_o), 64'd0);
    check(result_o === held, "R8", "result held", result_o, held);
    check(busy_o === 1'b0, "R9", "ignored start left no operation", 64'(busy_o), 64'd0);
  endtask

  logic [31:0] b_set [21];
  logic [31:0] a_set [6];
  logic [63:0] acc_set [2];

  initial begin
    b_set = '{32'h0, 32'h1, 32'h7F, 32'h80, 32'hFF, 32'h100, 32'h7FFF, 32'h8000,
              32'hFFFF, 32'h1_0000, 32'h7F_FFFF, 32'h80_0000, 32'hFF_FFFF, 32'h100_0000,
              32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FF80, 32'hFFFF_FF7F,
              32'hFFFF_8000, 32'hFF80_0000};
    a_set = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678, 32'h7FFF_FFFF};
    acc_set = '{64'hFEDC_BA98_7654_3210, 64'hFFFF_FFFF_FFFF_FFFF};

    rst_n = 1'b0; start_i = 1'b0;
    a_i = '0; b_i = '0; acc_i = '0;
    acc_mode_i = 1'b0; wide_i = 1'b0; signed_i = 1'b0;
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0, "R1", "flags in reset",
          {62'h0, busy_o, done_o}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy_o === 1'b0, "R1", "busy after reset", 64'(busy_o), 64'd0);
    check(done_o === 1'b0, "R1", "done after reset", 64'(done_o), 64'd0);
    check(result_o === 64'h0, "R1", "result after reset", result_o, 64'h0);

    // sweep: every mode, boundary multipliers, extreme multiplicands
    for (int m = 0; m < 8; m++) begin
      for (int bi = 0; bi < 21; bi++) begin
        for (int ai = 0; ai < 6; ai++) begin
          run_op(a_set[ai], b_set[bi], acc_set[(ai + bi) % 2],
                 m[2], m[1], m[0], ((ai + bi + m) % 11) == 0);
        end
      end
    end

    // random operands with lengths spread over all step counts
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      logic [63:0] racc;
      logic [3:0]  rm;
      ra   = $urandom;
      rb   = $urandom >> ($urandom % 32);
      if ($urandom % 2 == 1) rb = ~rb;
      racc = {$urandom, $urandom};
      rm   = 4'($urandom);
      run_op(ra, rb, racc, rm[2], rm[1], rm[0], (i % 7) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R3 watchdog: actual no completion expected completion within %0d cycles",
             WATCHDOG);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule